// File: doc/BRIEF.md
# Load-Use Hazard Stall Unit

This block guards an in-order five-stage pipeline against the one data hazard that forwarding cannot cover: an instruction in decode needs a register that a load in execute has not yet fetched from memory. When the hazard is detected, the block raises a stall. The PC and the decode latch keep their contents, and a nop is written into the execute latch in place of the decode instruction. On the next cycle the same decode instruction is evaluated again. By then the load has moved to the memory stage, so the dependency costs exactly one bubble cycle.

Detection uses the operation class of each instruction to decide which source fields count. A field that the decode instruction does not read is ignored. A load whose destination is register 0 never stalls. A store whose data register matches the load's destination does not stall either, because that value can still be forwarded to the memory stage in time. A store whose address register matches does stall. The block is packaged with a minimal model of the PC, the decode latch, the execute latch and the memory latch, so the bubble can be seen moving down the pipeline.

The operation class is 3 bits wide, with these encodings: nop = 0, register-register ALU = 1, register-immediate ALU = 2, load = 3, store = 4. Register fields are 5 bits wide. Each fetched instruction has four fields: class, first source, second source and destination.

Top module: `load_use_stall`

## Requirements
- R1: A stall is raised only when the execute-latch instruction has class load (3).
- R2: A load in execute with destination d stalls a decode instruction of class 1 or 4 whose second source equals d.
- R3: A load in execute with destination d stalls a decode instruction of class 1, 2 or 3 whose first source equals d. For class 4 (store), the first source is the store data and a match does not stall.
- R4: Source fields that the decode class does not read cannot cause a stall. Class 0 reads neither source. Classes 2 and 3 do not read the second source.
- R5: A load whose destination is register 0 never causes a stall.
- R6: pc_hold_o, dec_hold_o and bubble_o are each equal to stall_o in every cycle.
- R7: In the cycle after a stall, pc_o is unchanged and the execute latch holds a nop. Without a stall, pc_o increments by one each cycle.
- R8: The execute-latch instruction moves into the memory latch on every clock edge, whether or not a stall is active.
- R9: A load followed directly by a dependent instruction costs exactly one bubble. After that cycle stall_o is low, and the dependent instruction, with its destination intact, is in the execute latch.
- R10: After reset, pc_o is 0, the execute and memory latches hold nops, and stall_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fetch_op_i | input | 3 | Class of the instruction at pc_o |
| fetch_rs1_i | input | 5 | First source field of the fetched instruction |
| fetch_rs2_i | input | 5 | Second source field of the fetched instruction |
| fetch_rd_i | input | 5 | Destination field of the fetched instruction |
| pc_o | output | PC_W | Current fetch address |
| stall_o | output | 1 | Load-use hazard detected this cycle |
| pc_hold_o | output | 1 | PC keeps its value at the next edge |
| dec_hold_o | output | 1 | Decode latch keeps its value at the next edge |
| bubble_o | output | 1 | Nop is written into the execute latch at the next edge |
| ex_op_o | output | 3 | Class held in the execute latch |
| ex_rd_o | output | 5 | Destination held in the execute latch |
| mem_op_o | output | 3 | Class held in the memory latch |
| mem_rd_o | output | 5 | Destination held in the memory latch |

## Verification
The bench tries every pair of an execute-stage instruction and a decode-stage instruction over all five classes, three destination values including register 0, and three values for each source field. This covers the store-data exemption, which a naive detector would turn into a needless bubble. It also covers masked fields, where leftover bits in an immediate-form instruction would cause a false stall. For each pair the bench follows the pipeline for two more cycles. A design that did not hold the decode latch would lose the dependent instruction. A design that failed to inject the nop would run that instruction twice, and a design that stopped the execute stage would leave the load stuck and stall forever.

// File: rtl/lu_pkg.sv
package lu_pkg;
  localparam int REG_W = 5;

  typedef enum logic [2:0] {
    OPC_NOP    = 3'd0,
    OPC_ALU_RR = 3'd1,
    OPC_ALU_RI = 3'd2,
    OPC_LOAD   = 3'd3,
    OPC_STORE  = 3'd4
  } op_e;

  typedef struct packed {
    op_e              op;
    logic [REG_W-1:0] rs1;
    logic [REG_W-1:0] rs2;
    logic [REG_W-1:0] rd;
  } instr_t;

  localparam int INSTR_W = $bits(instr_t);

  function automatic logic reads_rs1(op_e op);
    return op inside {OPC_ALU_RR, OPC_ALU_RI, OPC_LOAD, OPC_STORE};
  endfunction

  function automatic logic reads_rs2(op_e op);
    return op inside {OPC_ALU_RR, OPC_STORE};
  endfunction
endpackage

// File: rtl/lu_detect.sv
module lu_detect
  import lu_pkg::*;
(
  input  instr_t dec_i,
  input  instr_t ex_i,
  output logic   stall_o
);
  logic ex_is_load, hit1, hit2;

  assign ex_is_load = (ex_i.op == OPC_LOAD) && (ex_i.rd != '0);
  // store data (rs1) can still be forwarded into the memory stage
  assign hit1 = reads_rs1(dec_i.op) && (dec_i.op != OPC_STORE) && (dec_i.rs1 == ex_i.rd);
  assign hit2 = reads_rs2(dec_i.op) && (dec_i.rs2 == ex_i.rd);
  assign stall_o = ex_is_load && (hit1 || hit2);
endmodule

// File: rtl/lu_stage.sv
module lu_stage #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         hold_i,
  input  logic         clear_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      q_o <= '0;
    else if (clear_i) q_o <= '0;
    else if (!hold_i) q_o <= d_i;
  end
endmodule

// File: rtl/lu_pc.sv
module lu_pc #(
  parameter int PC_W = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            hold_i,
  output logic [PC_W-1:0] pc_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      pc_o <= '0;
    else if (!hold_i) pc_o <= pc_o + 1'b1;
  end
endmodule

// File: rtl/load_use_stall.sv
module load_use_stall
  import lu_pkg::*;
#(
  parameter int PC_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [2:0]       fetch_op_i,
  input  logic [REG_W-1:0] fetch_rs1_i,
  input  logic [REG_W-1:0] fetch_rs2_i,
  input  logic [REG_W-1:0] fetch_rd_i,
  output logic [PC_W-1:0]  pc_o,
  output logic             stall_o,
  output logic             pc_hold_o,
  output logic             dec_hold_o,
  output logic             bubble_o,
  output logic [2:0]       ex_op_o,
  output logic [REG_W-1:0] ex_rd_o,
  output logic [2:0]       mem_op_o,
  output logic [REG_W-1:0] mem_rd_o
);
  instr_t fetch_w, dec_q, ex_q, mem_q;
  logic   stall_w;

  assign fetch_w = '{op: op_e'(fetch_op_i), rs1: fetch_rs1_i,
                     rs2: fetch_rs2_i, rd: fetch_rd_i};

  lu_detect u_detect (
    .dec_i  (dec_q),
    .ex_i   (ex_q),
    .stall_o(stall_w)
  );

  lu_pc #(.PC_W(PC_W)) u_pc (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .hold_i(stall_w),
    .pc_o  (pc_o)
  );

  lu_stage #(.W(INSTR_W)) u_dec (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .hold_i (stall_w),
    .clear_i(1'b0),
    .d_i    (fetch_w),
    .q_o    (dec_q)
  );

  lu_stage #(.W(INSTR_W)) u_ex (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .hold_i (1'b0),
    .clear_i(stall_w),
    .d_i    (dec_q),
    .q_o    (ex_q)
  );

  lu_stage #(.W(INSTR_W)) u_mem (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .hold_i (1'b0),
    .clear_i(1'b0),
    .d_i    (ex_q),
    .q_o    (mem_q)
  );

  assign stall_o    = stall_w;
  assign pc_hold_o  = stall_w;
  assign dec_hold_o = stall_w;
  assign bubble_o   = stall_w;
  assign ex_op_o    = ex_q.op;
  assign ex_rd_o    = ex_q.rd;
  assign mem_op_o   = mem_q.op;
  assign mem_rd_o   = mem_q.rd;
endmodule

// File: rtl/lu_stall_chk.sv
module lu_stall_chk #(
  parameter int PC_W  = 8,
  parameter int REG_W = 5
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [PC_W-1:0]  pc_o,
  input logic             stall_o,
  input logic [2:0]       ex_op_o,
  input logic [REG_W-1:0] ex_rd_o,
  input logic [2:0]       mem_op_o,
  input logic [REG_W-1:0] mem_rd_o
);
  assert_load_only_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |-> ex_op_o == 3'd3);

  assert_no_r0_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |-> ex_rd_o != '0);

  assert_bubble_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |=> ex_op_o == 3'd0);

  assert_pc_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |=> $stable(pc_o));

  assert_pc_step_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stall_o |=> pc_o == PC_W'($past(pc_o) + 1'b1));

  assert_advance_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (mem_op_o == $past(ex_op_o)) && (mem_rd_o == $past(ex_rd_o)));

  assert_one_bubble_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |=> !stall_o);
endmodule

bind load_use_stall lu_stall_chk #(.PC_W(PC_W), .REG_W(lu_pkg::REG_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .pc_o    (pc_o),
  .stall_o (stall_o),
  .ex_op_o (ex_op_o),
  .ex_rd_o (ex_rd_o),
  .mem_op_o(mem_op_o),
  .mem_rd_o(mem_rd_o)
);

// File: tb/tb_load_use_stall.sv
`timescale 1ns/1ps
module tb_load_use_stall;
  localparam int PC_W = 8;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [2:0] fetch_op;
  logic [4:0] fetch_rs1, fetch_rs2, fetch_rd;
  logic [PC_W-1:0] pc;
  logic stall, pc_hold, dec_hold, bubble;
  logic [2:0] ex_op, mem_op;
  logic [4:0] ex_rd, mem_rd;

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  // instruction A at address 0, B at address 1, nops elsewhere
  logic [2:0] a_op, b_op;
  logic [4:0] a_rs1, a_rs2, a_rd, b_rs1, b_rs2, b_rd;

  always #2 clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d cycles expected<=100000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  always_comb begin
    fetch_op = 3'd0; fetch_rs1 = '0; fetch_rs2 = '0; fetch_rd = '0;
    if (pc == 0) begin
      fetch_op = a_op; fetch_rs1 = a_rs1; fetch_rs2 = a_rs2; fetch_rd = a_rd;
    end else if (pc == 1) begin
      fetch_op = b_op; fetch_rs1 = b_rs1; fetch_rs2 = b_rs2; fetch_rd = b_rd;
    end
  end

  load_use_stall #(.PC_W(PC_W)) dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .fetch_op_i(fetch_op), .fetch_rs1_i(fetch_rs1),
    .fetch_rs2_i(fetch_rs2), .fetch_rd_i(fetch_rd),
    .pc_o(pc), .stall_o(stall), .pc_hold_o(pc_hold),
    .dec_hold_o(dec_hold), .bubble_o(bubble),
    .ex_op_o(ex_op), .ex_rd_o(ex_rd), .mem_op_o(mem_op), .mem_rd_o(mem_rd)
  );

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d (A op%0d rd%0d, B op%0d rs1=%0d rs2=%0d)",
               req, act, exp, a_op, a_rd, b_op, b_rs1, b_rs2);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic expect_stall(int xo, int xr, int dop, int r1, int r2);
    logic use1, use2;
    use1 = (dop == 1) || (dop == 2) || (dop == 3);  // R3: store rs1 exempt
    use2 = (dop == 1) || (dop == 4);                // R4: masking
    return (xo == 3) && (xr != 0) &&
           ((use1 && r1 == xr) || (use2 && r2 == xr));
  endfunction

  initial begin
    logic e;
    a_op = '0; a_rs1 = '0; a_rs2 = '0; a_rd = '0;
    b_op = '0; b_rs1 = '0; b_rs2 = '0; b_rd = '0;
    for (int xo = 0; xo < 5; xo++)
      for (int xr = 0; xr < 3; xr++)
        for (int dop = 0; dop < 5; dop++)
          for (int r1 = 0; r1 < 3; r1++)
            for (int r2 = 0; r2 < 3; r2++) begin
              rst_ni = 1'b0;
              a_op = 3'(xo); a_rd = 5'(xr); a_rs1 = 5'd9; a_rs2 = 5'd10;
              b_op = 3'(dop); b_rs1 = 5'(r1); b_rs2 = 5'(r2); b_rd = 5'd7;
              @(negedge clk);
              rst_ni = 1'b1;
              @(negedge clk);
              // R10 reset state, edge after release has loaded A into decode
              chk(pc == 1, "R10 pc after first edge", int'(pc), 1);
              chk(ex_op == 0 && mem_op == 0 && !stall, "R10 latches nop", int'(ex_op), 0);
              step();  // A in execute, B in decode
              e = expect_stall(xo, xr, dop, r1, r2);
              if (xo != 3)
                chk(stall == 1'b0, "R1 non-load", int'(stall), 0);
              else if (xr == 0)
                chk(stall == 1'b0, "R5 dest r0", int'(stall), 0);
              else if (dop == 4 && r1 == xr && r2 != xr)
                chk(stall == 1'b0, "R3 store data exempt", int'(stall), 0);
              else if ((dop == 0 || dop == 2 || dop == 3) && r2 == xr && !(dop != 0 && r1 == xr))
                chk(stall == 1'b0, "R4 unused field", int'(stall), 0);
              else if (r2 == xr && (dop == 1 || dop == 4))
                chk(stall == 1'b1, "R2 rs2 match", int'(stall), 1);
              else
                chk(stall == e, "R3 rs1 match", int'(stall), int'(e));
              chk(pc_hold == e && dec_hold == e && bubble == e, "R6 controls",
                  {pc_hold, dec_hold, bubble}, {3{e}});
              chk(ex_op == a_op && ex_rd == a_rd, "R8 A in execute", int'(ex_op), int'(a_op));
              step();
              chk(mem_op == a_op && mem_rd == a_rd, "R8 A advances", int'(mem_rd), int'(a_rd));
              if (e) begin
                chk(pc == 2, "R7 pc held", int'(pc), 2);
                chk(ex_op == 0, "R7 bubble in execute", int'(ex_op), 0);
                chk(!stall, "R9 single stall", int'(stall), 0);
                step();
                chk(ex_op == b_op && ex_rd == 7, "R9 dependent enters execute",
                    int'(ex_rd), 7);
                chk(pc == 3 && mem_op == 0, "R9 bubble to memory", int'(pc), 3);
              end else begin
                chk(pc == 3, "R7 pc steps", int'(pc), 3);
                chk(ex_op == b_op && ex_rd == 7, "R7 B advances", int'(ex_rd), 7);
              end
            end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule